// File: doc/BRIEF.md
# DMA Interrupt Mask and Aggregation Block

This block collects completion events from the channels of a multi-channel DMA engine and turns them into one interrupt line for the host. It has three event groups. The transmit group and the receive group each have one bit per channel. The third is an engine-level group whose only live source is a host-error condition.

Each group keeps three things:
- a raw status vector, which events set and per-bit acknowledge inputs clear;
- an enable mask;
- a masked view, which is the raw status ANDed with the mask.

Software never writes the mask directly. Instead it writes ones to a set register or to a clear register. This means two drivers that own different channels can never undo each other's mask changes.

The interrupt output follows the OR of every masked bit. Software acknowledges the interrupt by writing an end-of-interrupt register. That write forces the line low for one cycle, so an edge-sensitive interrupt controller sees a fresh rising edge when work is still pending. A vector register gathers all masked bits into one word.

Top module: `dma_irq_agg`

## Requirements
- R1: Each group has four word registers at its base address: raw status at base+0x0, masked status at base+0x4, mask-set at base+0x8 and mask-clear at base+0xC. The bases are 0x80 for transmit, 0xA0 for receive and 0xB0 for the engine-level group. Channel N of a direction occupies bit N of that direction's registers.
- R2: Writing the mask-set register turns on every mask bit written as 1 and leaves the bits written as 0 unchanged. The new mask is readable on the next cycle.
- R3: Writing the mask-clear register turns off every mask bit written as 1 and leaves the bits written as 0 unchanged. Writing 0xFFFFFFFF therefore disables the whole group.
- R4: A read of the mask-set register and a read of the mask-clear register of a group both return that group's current mask.
- R5: An event pulse on a bit sets that raw bit, and an acknowledge pulse clears it. Either change is visible one cycle later. When an event and an acknowledge hit the same bit in the same cycle, the event wins and the bit ends up set.
- R6: The masked status register always reads as the raw status ANDed with the mask.
- R7: The engine-level host error occupies bit 1 of the engine-level group. Bit 0 of that group's raw status always reads 0.
- R8: The interrupt output is 1 exactly one cycle after the OR of all masked bits across the three groups is 1, unless an end-of-interrupt write occurred in that cycle.
- R9: A write to address 0x94 (end of interrupt) drives the interrupt output low on the next cycle. If any masked bit is still set, the output goes high again one cycle after that.
- R10: The vector register at 0x90 reads as follows: transmit masked bits in [NCH-1:0], receive masked bits in [2*NCH-1:NCH], engine-level masked bits in [2*NCH+1:2*NCH]. Writes to the vector, raw status or masked status registers change no state.
- R11: A read of any address that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address for register access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational decode of bus_addr |
| tx_evt | input | NCH | Transmit channel event pulses |
| tx_ack | input | NCH | Transmit channel raw-status acknowledges |
| rx_evt | input | NCH | Receive channel event pulses |
| rx_ack | input | NCH | Receive channel raw-status acknowledges |
| host_err_evt | input | 1 | Engine-level host-error event pulse |
| host_err_ack | input | 1 | Host-error raw-status acknowledge |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Register reads are combinational. A mask write or an event/acknowledge pulse is therefore visible on bus_rdata in the cycle after the edge that sampled it. The interrupt output lags the masked status by one further register stage. After an end-of-interrupt write, it is low for exactly the next cycle and reflects the pending state again the cycle after.

The bench drives all inputs on the falling edge and returns from each write or pulse on the following falling edge. Register values are sampled at that point. The interrupt output is sampled either at that same point, for the end-of-interrupt low cycle, or one full cycle later, for the rise caused by new masked status.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW = 32;
  localparam int AW = 8;
  // Group blocks decoded from address bits [7:4]
  localparam logic [3:0] BLK_TX  = 4'h8;
  localparam logic [3:0] BLK_RX  = 4'hA;
  localparam logic [3:0] BLK_DMA = 4'hB;
  // Register slot within a group, address bits [3:2]
  localparam logic [1:0] SLOT_RAW = 2'd0;
  localparam logic [1:0] SLOT_MSK = 2'd1;
  localparam logic [1:0] SLOT_SET = 2'd2;
  localparam logic [1:0] SLOT_CLR = 2'd3;
  localparam logic [AW-1:0] ADDR_VEC = 8'h90;
  localparam logic [AW-1:0] ADDR_EOI = 8'h94;
  // Engine-level group
  localparam int DMA_W        = 2;
  localparam int HOST_ERR_BIT = 1;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ack,
  output logic [W-1:0] raw,
  output logic [W-1:0] mask,
  output logic [W-1:0] masked
);
  logic [W-1:0] raw_q, raw_d, mask_q, mask_d;
  logic         raw_en, mask_en;

  always_comb begin
    raw_en = (|evt) | (|ack);
    raw_d  = (raw_q & ~ack) | evt;   // event wins over acknowledge
    mask_en = set_we | clr_we;
    mask_d  = mask_q;
    if (set_we)      mask_d = mask_q | wdata;
    else if (clr_we) mask_d = mask_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (raw_en) raw_q <= raw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((mask & $past(wdata)) == $past(wdata)));
  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((mask & $past(wdata)) == '0));
  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(mask));
  // R5
  raw_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));
  // R5
  raw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0 && ack == '0) |=> $stable(raw));
endmodule

// File: rtl/irq_eoi_gate.sv
module irq_eoi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic eoi_we,
  output logic irq
);
  logic irq_q, irq_d;

  always_comb irq_d = any_pend & ~eoi_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R9
  eoi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we |=> !irq);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_pend));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NCH-1:0] tx_evt,
  input  logic [NCH-1:0] tx_ack,
  input  logic [NCH-1:0] rx_evt,
  input  logic [NCH-1:0] rx_ack,
  input  logic          host_err_evt,
  input  logic          host_err_ack,
  output logic          irq_out
);
  localparam int VW = 2 * NCH + DMA_W;

  logic       rst_s_n;
  logic [3:0] blk;
  logic [1:0] slot;
  logic [1:0] dir_hit;
  logic       dma_hit, eoi_we, any_pend;

  logic [NCH-1:0] d_evt [2];
  logic [NCH-1:0] d_ack [2];
  logic [NCH-1:0] d_raw [2];
  logic [NCH-1:0] d_msk [2];
  logic [NCH-1:0] d_mkd [2];
  logic [DMA_W-1:0] dma_evt, dma_ack, dma_raw, dma_msk, dma_mkd;
  logic [VW-1:0] vec;

  irq_rst_sync u_rs (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_s_n));

  assign blk        = bus_addr[7:4];
  assign slot       = bus_addr[3:2];
  assign dir_hit[0] = (blk == BLK_TX);
  assign dir_hit[1] = (blk == BLK_RX);
  assign dma_hit    = (blk == BLK_DMA);
  assign eoi_we     = bus_wr && (bus_addr == ADDR_EOI);

  assign d_evt[0] = tx_evt;
  assign d_evt[1] = rx_evt;
  assign d_ack[0] = tx_ack;
  assign d_ack[1] = rx_ack;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    irq_group #(.W(NCH)) u_grp (
      .clk   (clk),
      .rst_n (rst_s_n),
      .set_we(bus_wr && dir_hit[d] && slot == SLOT_SET),
      .clr_we(bus_wr && dir_hit[d] && slot == SLOT_CLR),
      .wdata (bus_wdata[NCH-1:0]),
      .evt   (d_evt[d]),
      .ack   (d_ack[d]),
      .raw   (d_raw[d]),
      .mask  (d_msk[d]),
      .masked(d_mkd[d])
    );
  end

  always_comb begin
    dma_evt = '0;
    dma_ack = '0;
    dma_evt[HOST_ERR_BIT] = host_err_evt;
    dma_ack[HOST_ERR_BIT] = host_err_ack;
  end

  irq_group #(.W(DMA_W)) u_dma (
    .clk   (clk),
    .rst_n (rst_s_n),
    .set_we(bus_wr && dma_hit && slot == SLOT_SET),
    .clr_we(bus_wr && dma_hit && slot == SLOT_CLR),
    .wdata (bus_wdata[DMA_W-1:0]),
    .evt   (dma_evt),
    .ack   (dma_ack),
    .raw   (dma_raw),
    .mask  (dma_msk),
    .masked(dma_mkd)
  );

  assign vec      = {dma_mkd, d_mkd[1], d_mkd[0]};
  assign any_pend = |vec;

  irq_eoi_gate u_eoi (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .any_pend(any_pend),
    .eoi_we  (eoi_we),
    .irq     (irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_VEC) begin
      bus_rdata = DW'(vec);
    end else if (dma_hit) begin
      unique case (slot)
        SLOT_RAW: bus_rdata = DW'(dma_raw);
        SLOT_MSK: bus_rdata = DW'(dma_mkd);
        default:  bus_rdata = DW'(dma_msk);
      endcase
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (dir_hit[d]) begin
          unique case (slot)
            SLOT_RAW: bus_rdata = DW'(d_raw[d]);
            SLOT_MSK: bus_rdata = DW'(d_mkd[d]);
            default:  bus_rdata = DW'(d_msk[d]);
          endcase
        end
      end
    end
  end

  // R7
  host_bit0_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    dma_raw[0] == 1'b0);
  // R6
  vec_mask_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (vec[NCH-1:0] & ~d_msk[0]) == '0);
endmodule

// File: tb/sim_dma_irq_agg.sv
`timescale 1ns/1ps
module sim_dma_irq_agg;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] tx_evt, tx_ack, rx_evt, rx_ack;
  logic        host_err_evt, host_err_ack;
  logic        irq_out;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dma_irq_agg #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_evt(tx_evt), .tx_ack(tx_ack), .rx_evt(rx_evt), .rx_ack(rx_ack),
    .host_err_evt(host_err_evt), .host_err_ack(host_err_ack),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pulse(input int dir, input logic [NCH-1:0] e, input logic [NCH-1:0] k);
    if (dir == 0) begin tx_evt = e; tx_ack = k; end
    else          begin rx_evt = e; rx_ack = k; end
    @(negedge clk);
    tx_evt = '0; tx_ack = '0; rx_evt = '0; rx_ack = '0;
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  base;
    logic [7:0]  m, e, model;

    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    tx_evt = '0; tx_ack = '0; rx_evt = '0; rx_ack = '0;
    host_err_evt = 1'b0; host_err_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state, R1 map addresses, R11 unmapped
    for (int a = 8'h80; a <= 8'hBC; a += 4) begin
      rd(a[7:0], r); chk("R1 reset reg", r, 32'h0);
    end
    chk("R8 reset irq", {31'b0, irq_out}, 32'h0);
    rd(8'h40, r); chk("R11 unmapped", r, 32'h0);
    rd(8'hC0, r); chk("R11 unmapped", r, 32'h0);

    // R2 R3 R4 sweep of mask patterns in both directions
    for (int d = 0; d < 2; d++) begin
      base = (d == 0) ? 8'h80 : 8'hA0;
      model = '0;
      for (int i = 0; i < 256; i += 13) begin
        m = i[7:0];
        wr(base + 8'h8, {24'hFFFFFF, m}); model = model | m;
        rd(base + 8'h8, r); chk("R2 set read", r, {24'h0, model});
        rd(base + 8'hC, r); chk("R4 clr read", r, {24'h0, model});
        wr(base + 8'hC, {24'h0, m ^ 8'h3C}); model = model & ~(m ^ 8'h3C);
        rd(base + 8'h8, r); chk("R3 partial clear", r, {24'h0, model});
      end
      wr(base + 8'hC, 32'hFFFF_FFFF);
      rd(base + 8'h8, r); chk("R3 clear all", r, 32'h0);
    end

    // R5 R6 R8 R10 event sweep
    for (int d = 0; d < 2; d++) begin
      base = (d == 0) ? 8'h80 : 8'hA0;
      for (int i = 1; i < 256; i += 23) begin
        e = i[7:0];
        m = e ^ 8'hA5;
        wr(base + 8'hC, 32'hFFFF_FFFF);
        wr(base + 8'h8, {24'h0, m});
        pulse(d, e, '0);
        rd(base, r);        chk("R5 raw set", r, {24'h0, e});
        rd(base + 8'h4, r); chk("R6 masked", r, {24'h0, e & m});
        rd(8'h90, r);
        chk("R10 vector", r, (d == 0) ? {24'h0, e & m} : {16'h0, e & m, 8'h0});
        @(negedge clk);
        chk("R8 irq level", {31'b0, irq_out}, {31'b0, |(e & m)});
        pulse(d, '0, 8'hFF);
        rd(base, r); chk("R5 ack clear", r, 32'h0);
        @(negedge clk);
        chk("R8 irq drop", {31'b0, irq_out}, 32'h0);
      end
      wr(base + 8'hC, 32'hFFFF_FFFF);
    end

    // R5 event and ack on same bit: event wins
    pulse(0, 8'h08, 8'h08);
    rd(8'h80, r); chk("R5 event wins", r, 32'h8);
    pulse(0, 8'h00, 8'h08);
    rd(8'h80, r); chk("R5 ack alone", r, 32'h0);

    // R7 host error
    wr(8'hB8, 32'h2);
    rd(8'hB8, r); chk("R7 dma mask", r, 32'h2);
    host_err_evt = 1'b1; @(negedge clk); host_err_evt = 1'b0;
    rd(8'hB0, r); chk("R7 host raw bit1", r, 32'h2);
    rd(8'hB4, r); chk("R7 host masked", r, 32'h2);
    rd(8'h90, r); chk("R10 vector host", r, 32'h0002_0000);
    @(negedge clk);
    chk("R8 irq host", {31'b0, irq_out}, 32'h1);
    host_err_ack = 1'b1; @(negedge clk); host_err_ack = 1'b0;
    rd(8'hB0, r); chk("R7 host ack", r, 32'h0);
    wr(8'hBC, 32'hFFFF_FFFF);
    @(negedge clk);

    // R9 end of interrupt
    wr(8'h88, 32'h1);
    pulse(0, 8'h01, '0);
    @(negedge clk);
    chk("R9 irq before eoi", {31'b0, irq_out}, 32'h1);
    wr(8'h94, 32'h0);
    chk("R9 irq low after eoi", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R9 irq rearm", {31'b0, irq_out}, 32'h1);
    pulse(0, '0, 8'h01);
    @(negedge clk);
    wr(8'h94, 32'h0);
    @(negedge clk);
    chk("R9 no rearm when clear", {31'b0, irq_out}, 32'h0);

    // R10 writes to status and vector ignored
    pulse(0, 8'h40, '0);
    wr(8'h80, 32'hFF);
    wr(8'h84, 32'hFF);
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h80, r); chk("R10 raw write ignored", r, 32'h40);
    rd(8'h88, r); chk("R10 mask untouched", r, 32'h1);
    rd(8'h90, r); chk("R10 vector write ignored", r, 32'h0);

    finish_up();
  end
endmodule